// File: doc/BRIEF.md
# Paper Tape Reader and Punch Controller

This block sits between a byte-wide host I/O bus and a paper tape reader and punch. One busy flag and one interrupt line serve both units. The host issues four kinds of operation: a command byte, a data read, a data write and a status sense. The command byte holds four 2-bit fields. Each field can leave its mode bit alone, force it to one value, force it to the other, or flip it. The mode bits are interrupt enable, run, slew and direction.

Each unit's mechanical cycle is modelled by a delay counter. When a reader cycle has counted down, the controller raises `rdr_ready` and waits for the reader to offer a byte on `rdr_valid`/`rdr_data`. When a punch cycle has counted down, the controller offers the latched punch byte on `pun_valid` and waits for `pun_ready`. When the unit for the selected direction finishes a cycle while busy is set, busy clears and an interrupt request is latched. The request is visible on `irq` only while interrupt enable is set, and `irq_ack` removes it.

Operations on `op_kind` use this encoding: 0 is command, 1 is data read, 2 is data write and 3 is status sense. `rd_data` is combinational during a read or a sense cycle and zero otherwise.

Top module: `ptape_ctrl`

## Requirements
- R1: Command bits 5:4 control run. Code 1 sets run, 2 clears it, 3 flips it and 0 keeps it.
- R2: Command bits 3:2 control slew. Code 1 selects slew, 2 selects step, 3 flips it and 0 keeps it. In slew mode a finished reader cycle starts the next one at once, so the reader stays in motion.
- R3: Command bits 1:0 control direction. Code 1 selects read, 2 selects write, 3 flips it and 0 keeps it.
- R4: Command bits 7:6 control interrupt enable with the same 1/2/3 encoding. `irq` is the pending request gated by enable, and `irq_ack` clears the pending request.
- R5: After any command that leaves direction at read with run set, a reader cycle starts if the reader is idle.
- R6: After any command, busy is set if the unit for the new direction (punch for write, reader for read) has a cycle in progress. Otherwise, if busy was set, an interrupt request is latched and busy clears.
- R7: A data read returns the reader buffer. With run set and step selected it starts a reader cycle, and with direction at read it sets busy.
- R8: A data write latches the byte into the punch buffer and starts a punch cycle. With direction at write it sets busy. The byte appears on `pun_data` with `pun_valid` after PUN_DELAY rising edges, counting the edge that accepts the write.
- R9: A reader cycle raises `rdr_ready` after RD_DELAY rising edges, counting the edge that starts it. It completes when `rdr_valid` is seen with `rdr_ready`, and `rdr_data` is then loaded into the reader buffer. If direction is read at completion, a request is latched when busy was set, and busy clears.
- R10: A punch cycle completes when `pun_ready` is seen with `pun_valid`. If direction is write at completion, a request is latched when busy was set, and busy clears. In read direction a completion changes neither busy nor the request.
- R11: Status byte: bit 3 (0x08) is busy. Bits 4 (0x10) and 2 (0x04) are set while the reader has no cycle in progress. Bit 0 (0x01) is set while `tape_loaded` is low. All other bits are zero.
- R12: Synchronous reset clears busy, the pending request and all four mode bits, and cancels both unit cycles.
- R13: When a new request and `irq_ack` fall in the same cycle, the request is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Bus operation strobe, one cycle per operation |
| op_kind | input | 2 | 0 command, 1 data read, 2 data write, 3 status sense |
| op_data | input | 8 | Command byte or write data |
| rd_data | output | 8 | Reader buffer on a read, status byte on a sense, else zero |
| irq_ack | input | 1 | Clears the pending interrupt request |
| irq | output | 1 | Interrupt request gated by enable |
| tape_loaded | input | 1 | Low when no tape is mounted |
| rdr_ready | output | 1 | Reader cycle has counted down and awaits a byte |
| rdr_valid | input | 1 | Reader offers a byte |
| rdr_data | input | 8 | Reader byte |
| pun_valid | output | 1 | Punch byte offered after the punch delay |
| pun_ready | input | 1 | Punch takes the byte and ends its cycle |
| pun_data | output | 8 | Punch buffer |

## Verification
The assertions check rules that hold on every cycle. A read or write in the matching direction sets busy on the next cycle. A completion in the selected direction clears busy and latches a request. An acknowledge without a new request empties the request. A slewing reader is back in motion one cycle after it finishes. A waiting handshake holds until it is taken. Reset leaves every mode bit and cycle cleared. Only the bench scenarios can show the 2-bit field encodings, including the toggle and keep codes. They also show the exact delay to each handshake, the values returned by reads and senses, the masking of `irq` by enable, and busy resolving into an interrupt when a direction change leaves no unit moving.

// File: rtl/ptape_pkg.sv
package ptape_pkg;

    localparam int BYTE_W  = 8;
    localparam int NFIELDS = 4;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_SENSE = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        FLD_KEEP = 2'd0,
        FLD_ON   = 2'd1,
        FLD_OFF  = 2'd2,
        FLD_FLIP = 2'd3
    } fld_code_e;

    // bit 0 direction (1 = write), bit 1 slew, bit 2 run, bit 3 interrupt enable
    typedef struct packed {
        logic ien;
        logic run;
        logic slew;
        logic wr;
    } mode_t;

    // value each field takes for code FLD_ON, indexed like mode_t
    localparam logic [NFIELDS-1:0] FLD_ON_VAL = 4'b1110;

    localparam int ST_NMTN = 4;
    localparam int ST_BUSY = 3;
    localparam int ST_EXAM = 2;
    localparam int ST_UNAV = 0;

    function automatic logic fld_apply(input logic cur, input logic [1:0] code,
                                       input logic on_val);
        case (fld_code_e'(code))
            FLD_ON:   return on_val;
            FLD_OFF:  return ~on_val;
            FLD_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input logic busy,
                                                      input logic rdr_moving,
                                                      input logic loaded);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[ST_BUSY] = busy;
        s[ST_NMTN] = ~rdr_moving;
        s[ST_EXAM] = ~rdr_moving;
        s[ST_UNAV] = ~loaded;
        return s;
    endfunction

endpackage

// File: rtl/ptape_timer.sv
module ptape_timer #(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic go,
    output logic active,
    output logic due,
    output logic done
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);

    logic          act_q;
    logic [CW-1:0] cnt_q;

    assign active = act_q;
    assign due    = act_q && (cnt_q == '0);
    assign done   = due && go;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (start && (!act_q || done)) begin
            act_q <= 1'b1;
            cnt_q <= CW'(DELAY - 1);
        end else if (done) begin
            act_q <= 1'b0;
        end else if (act_q && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R9 / R10: an offered or awaited handshake stays until it is taken
    p_hold_due_r9: assert property (@(posedge clk) disable iff (rst)
        (due && !go) |=> due);

    p_stay_active_r10: assert property (@(posedge clk) disable iff (rst)
        (active && !done) |=> active);

endmodule

// File: rtl/ptape_mode_reg.sv
module ptape_mode_reg
    import ptape_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] cmd_byte,
    output mode_t             mode_q,
    output mode_t             mode_d
);
    logic [NFIELDS-1:0] cur_bits;
    logic [NFIELDS-1:0] nxt_bits;

    assign cur_bits = mode_q;
    assign mode_d   = mode_t'(nxt_bits);

    for (genvar i = 0; i < NFIELDS; i++) begin : g_field
        always_comb begin
            nxt_bits[i] = cmd_we ? fld_apply(cur_bits[i], cmd_byte[2*i+1 -: 2], FLD_ON_VAL[i])
                                 : cur_bits[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_d;
    end

    // R12: reset clears every mode bit
    p_mode_reset_r12: assert property (@(posedge clk)
        rst |=> (mode_q == '0));

endmodule

// File: rtl/ptape_busy_irq.sv
module ptape_busy_irq (
    input  logic clk,
    input  logic rst,
    input  logic dir_wr,
    input  logic rdr_done,
    input  logic pun_done,
    input  logic cmd_we,
    input  logic unit_moving_nx,
    input  logic rd_we,
    input  logic wr_we,
    input  logic ack,
    output logic busy,
    output logic pend
);
    logic busy_d, pend_d, done_cur;

    assign done_cur = dir_wr ? pun_done : rdr_done;

    always_comb begin
        busy_d = busy;
        pend_d = pend && !ack;
        if (done_cur) begin
            if (busy) pend_d = 1'b1;
            busy_d = 1'b0;
        end
        if (cmd_we) begin
            if (unit_moving_nx) begin
                busy_d = 1'b1;
            end else begin
                if (busy_d) pend_d = 1'b1;
                busy_d = 1'b0;
            end
        end
        if (rd_we && !dir_wr) busy_d = 1'b1;
        if (wr_we && dir_wr)  busy_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pend <= 1'b0;
        end else begin
            busy <= busy_d;
            pend <= pend_d;
        end
    end

    // R9/R10: completion in selected direction with no bus op clears busy
    p_done_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (done_cur && !cmd_we && !rd_we && !wr_we) |=> !busy);

    // R13: a completion while busy latches a request even under acknowledge
    p_req_wins_r13: assert property (@(posedge clk) disable iff (rst)
        (done_cur && busy) |=> pend);

    // R4: acknowledge without new request empties the request
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (ack && !done_cur && !cmd_we) |=> !pend);

    // R12
    p_reset_idle_r12: assert property (@(posedge clk)
        rst |=> (!busy && !pend));

endmodule

// File: rtl/ptape_ctrl.sv
module ptape_ctrl
    import ptape_pkg::*;
#(
    parameter int RD_DELAY  = 4,
    parameter int PUN_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [BYTE_W-1:0] op_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              irq_ack,
    output logic              irq,
    input  logic              tape_loaded,
    output logic              rdr_ready,
    input  logic              rdr_valid,
    input  logic [BYTE_W-1:0] rdr_data,
    output logic              pun_valid,
    input  logic              pun_ready,
    output logic [BYTE_W-1:0] pun_data
);
    bus_op_e op;
    logic    is_cmd, is_rd, is_wr, is_sense;

    assign op       = bus_op_e'(op_kind);
    assign is_cmd   = op_valid && (op == OP_CMD);
    assign is_rd    = op_valid && (op == OP_READ);
    assign is_wr    = op_valid && (op == OP_WRITE);
    assign is_sense = op_valid && (op == OP_SENSE);

    mode_t md, md_nx;

    ptape_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (is_cmd),
        .cmd_byte (op_data),
        .mode_q   (md),
        .mode_d   (md_nx)
    );

    logic rdr_start, rdr_act, rdr_due, rdr_done;
    logic pun_start, pun_act, pun_due, pun_done;

    assign rdr_start = (is_cmd && !md_nx.wr && md_nx.run)
                     || (is_rd && md.run && !md.slew)
                     || (rdr_done && md.slew);
    assign pun_start = is_wr;

    ptape_timer #(.DELAY(RD_DELAY)) u_rdr_tmr (
        .clk    (clk),
        .rst    (rst),
        .start  (rdr_start),
        .go     (rdr_valid),
        .active (rdr_act),
        .due    (rdr_due),
        .done   (rdr_done)
    );

    ptape_timer #(.DELAY(PUN_DELAY)) u_pun_tmr (
        .clk    (clk),
        .rst    (rst),
        .start  (pun_start),
        .go     (pun_ready),
        .active (pun_act),
        .due    (pun_due),
        .done   (pun_done)
    );

    logic rdr_moving_nx, pun_moving_nx, unit_moving_nx;
    assign rdr_moving_nx  = (rdr_act && !rdr_done) || rdr_start;
    assign pun_moving_nx  = (pun_act && !pun_done) || pun_start;
    assign unit_moving_nx = md_nx.wr ? pun_moving_nx : rdr_moving_nx;

    logic busy, pend;

    ptape_busy_irq u_busy (
        .clk            (clk),
        .rst            (rst),
        .dir_wr         (md.wr),
        .rdr_done       (rdr_done),
        .pun_done       (pun_done),
        .cmd_we         (is_cmd),
        .unit_moving_nx (unit_moving_nx),
        .rd_we          (is_rd),
        .wr_we          (is_wr),
        .ack            (irq_ack),
        .busy           (busy),
        .pend           (pend)
    );

    logic [BYTE_W-1:0] rbuf_q, pbuf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbuf_q <= '0;
            pbuf_q <= '0;
        end else begin
            if (rdr_done) rbuf_q <= rdr_data;
            if (is_wr)    pbuf_q <= op_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (is_rd)         rd_data = rbuf_q;
        else if (is_sense) rd_data = status_byte(busy, rdr_act, tape_loaded);
    end

    assign irq       = pend && md.ien;
    assign rdr_ready = rdr_due;
    assign pun_valid = pun_due;
    assign pun_data  = pbuf_q;

    // R7: a read in read direction leaves busy set
    p_read_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (is_rd && !md.wr) |=> busy);

    // R8: a write in write direction leaves busy set
    p_write_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (is_wr && md.wr) |=> busy);

    // R5: a command ending in read+run leaves the reader moving
    p_cmd_start_r5: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && !md_nx.wr && md_nx.run) |=> rdr_act);

    // R2: slewing reader restarts right after a completion
    p_slew_restart_r2: assert property (@(posedge clk) disable iff (rst)
        (rdr_done && md.slew) |=> rdr_act);

    // R12: reset cancels both unit cycles
    p_reset_cancel_r12: assert property (@(posedge clk)
        rst |=> (!rdr_act && !pun_act));

endmodule

// File: tb/ptape_ctrl_tb_top.sv
`timescale 1ns/1ps
module ptape_ctrl_tb_top;
    localparam int RD_D = 4;
    localparam int PN_D = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic [7:0] op_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic       tape_loaded = 1'b0;
    logic       rdr_ready;
    logic       rdr_valid = 1'b0;
    logic [7:0] rdr_data = 8'h00;
    logic       pun_valid;
    logic       pun_ready = 1'b0;
    logic [7:0] pun_data;

    always #2.5 clk = ~clk;

    ptape_ctrl #(.RD_DELAY(RD_D), .PUN_DELAY(PN_D)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_data(op_data), .rd_data(rd_data), .irq_ack(irq_ack), .irq(irq),
        .tape_loaded(tape_loaded), .rdr_ready(rdr_ready), .rdr_valid(rdr_valid),
        .rdr_data(rdr_data), .pun_valid(pun_valid), .pun_ready(pun_ready),
        .pun_data(pun_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: one bus operation, expected response queued for the monitor
    task automatic bus_op(input logic [1:0] kind, input logic [7:0] data,
                          input logic [7:0] exp, input string tag);
        @(negedge clk);
        op_valid = 1'b1;
        op_kind  = kind;
        op_data  = data;
        if (kind == 2'd1 || kind == 2'd3) sb_q.push_back('{exp, tag});
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        bus_op(2'd0, c, 8'h00, "");
    endtask

    task automatic sense(input logic [7:0] exp, input string tag);
        bus_op(2'd3, 8'h00, exp, tag);
    endtask

    // monitor: pops expected responses as the design drives them
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (op_valid && (op_kind == 2'd1 || op_kind == 2'd3)) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "SB unexpected response", rd_data, 0);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    check(rd_data === it.exp, it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic feed_rdr(input logic [7:0] d);
        while (!rdr_ready) @(negedge clk);
        rdr_valid = 1'b1;
        rdr_data  = d;
        @(negedge clk);
        rdr_valid = 1'b0;
    endtask

    task automatic take_pun(input bit with_ack);
        while (!pun_valid) @(negedge clk);
        pun_ready = 1'b1;
        irq_ack   = with_ack;
        @(negedge clk);
        pun_ready = 1'b0;
        irq_ack   = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state, status encoding (R11, R12)
        check(irq === 1'b0 && rdr_ready === 1'b0 && pun_valid === 1'b0,
              "R12 outputs idle after reset", irq, 0);
        sense(8'h15, "R11 status no tape");
        tape_loaded = 1'b1;
        sense(8'h14, "R11 status idle tape loaded");

        // enable + run + read: reader starts, busy set (R4, R5, R6, R9)
        cmd(8'h51);
        n = 1;
        while (!rdr_ready) begin @(negedge clk); n++; end
        check(n == RD_D, "R9 reader delay", n, RD_D);
        sense(8'h08, "R5 R6 busy with reader moving");
        check(irq === 1'b0, "R9 no irq before completion", irq, 0);
        feed_rdr(8'hA5);
        check(irq === 1'b1, "R9 completion raises irq", irq, 1);
        sense(8'h14, "R9 busy cleared reader idle in step");

        // read in step+run: returns byte, restarts reader, sets busy (R7)
        bus_op(2'd1, 8'h00, 8'hA5, "R7 read returns reader buffer");
        sense(8'h08, "R7 read restarts reader and sets busy");
        ack();
        check(irq === 1'b0, "R4 ack clears irq", irq, 0);

        // enable off masks irq (R4)
        cmd(8'h80);
        feed_rdr(8'h3C);
        check(irq === 1'b0, "R4 irq masked when disabled", irq, 0);
        cmd(8'h40);
        check(irq === 1'b1, "R4 enable reveals pending request", irq, 1);
        ack();

        // slew mode: auto restart (R2)
        cmd(8'h04);
        feed_rdr(8'h11);
        sense(8'h00, "R2 slew keeps reader moving, busy cleared");
        ack();
        bus_op(2'd1, 8'h00, 8'h11, "R7 read after slew completion");

        // stop + step, then run field codes (R1)
        cmd(8'h28);
        feed_rdr(8'h22);
        sense(8'h14, "R2 step stops after completion");
        ack();
        cmd(8'h01);
        sense(8'h14, "R1 run cleared, no start");
        cmd(8'h30);
        sense(8'h08, "R1 toggle sets run and starts reader");
        feed_rdr(8'h33);
        ack();
        cmd(8'h30);
        sense(8'h14, "R1 toggle clears run");
        cmd(8'h10);
        feed_rdr(8'h44);
        ack();
        cmd(8'h00);
        sense(8'h08, "R1 code 0 keeps run, reader restarts");
        feed_rdr(8'h55);
        ack();
        cmd(8'h0C);
        feed_rdr(8'h66);
        sense(8'h00, "R2 toggle selects slew");
        ack();
        cmd(8'h2C);
        feed_rdr(8'h67);
        sense(8'h14, "R2 toggle back to step");
        ack();

        // write direction punch (R3, R8, R10)
        cmd(8'h02);
        bus_op(2'd2, 8'h5A, 8'h00, "");
        n = 1;
        while (!pun_valid) begin @(negedge clk); n++; end
        check(n == PN_D, "R8 punch delay", n, PN_D);
        check(pun_data === 8'h5A, "R8 punch data", pun_data, 8'h5A);
        sense(8'h1C, "R8 write in write direction sets busy");
        take_pun(1'b0);
        check(irq === 1'b1, "R10 punch completion raises irq", irq, 1);
        ack();

        // toggle to read: write does not set busy, completion ignored (R3, R10)
        cmd(8'h03);
        bus_op(2'd2, 8'h77, 8'h00, "");
        sense(8'h14, "R3 read direction: write leaves busy clear");
        while (!pun_valid) @(negedge clk);
        check(pun_data === 8'h77, "R8 punch data second byte", pun_data, 8'h77);
        take_pun(1'b0);
        check(irq === 1'b0, "R10 completion in read direction ignored", irq, 0);

        // busy resolves on direction change with reader idle (R6)
        cmd(8'h03);
        bus_op(2'd2, 8'h66, 8'h00, "");
        cmd(8'h03);
        check(irq === 1'b1, "R6 command with idle unit converts busy to irq", irq, 1);
        sense(8'h14, "R6 busy cleared by command");
        take_pun(1'b0);
        ack();
        check(irq === 1'b0, "R4 ack after R6", irq, 0);

        // request vs ack in same cycle (R13)
        cmd(8'h03);
        bus_op(2'd2, 8'h12, 8'h00, "");
        take_pun(1'b1);
        check(irq === 1'b1, "R13 request kept over ack", irq, 1);
        ack();

        // reset mid-cycle (R12)
        bus_op(2'd2, 8'h99, 8'h00, "");
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        sense(8'h14, "R12 reset clears busy");
        repeat (PN_D + 3) @(negedge clk);
        check(pun_valid === 1'b0, "R12 reset cancels punch cycle", pun_valid, 0);
        cmd(8'h01);
        sense(8'h14, "R12 run cleared by reset");
        check(irq === 1'b0, "R12 enable cleared by reset", irq, 0);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "SB all responses seen", sb_q.size(), 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule